// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative address translation buffer. Each of its entries covers a pair of neighbouring 4 KB virtual pages: one tag names the pair, and the entry carries two physical frame numbers, one for the even page and one for the odd page. Each frame has its own valid bit. On a lookup, every entry compares its tag with the page-pair number of the request at the same time. Virtual address bit 12 then picks which of the two frames of the matching entry forms the physical address.

Entries are loaded through an indexed write port, which replaces the tag, both frames and both valid bits of one entry in a single cycle. Lookups are pipelined over two stages. The first stage compares the tags, resolves multiple matches and captures the chosen entry. The second stage picks the even or odd frame and registers the response. A new lookup can be issued every cycle, and each response appears two cycles after its request.

Top module: `paired_tlb`

## Requirements
- R1: A lookup request presented with `lk_req` high in cycle n produces `rsp_stb` high in cycle n+2 and in no other cycle. Back-to-back requests give back-to-back responses, in order.
- R2: A lookup hits (`rsp_hit`=1) when an entry holds at least one valid half and its tag equals virtual address bits 39:13.
- R3: On a hit, virtual address bit 12 picks the frame: 0 selects the even frame and 1 selects the odd frame. `rsp_pa` is the selected 24-bit frame in bits 35:12, with virtual address bits 11:0 copied unchanged into bits 11:0.
- R4: A lookup that matches no entry returns `rsp_hit`=0, `rsp_pg_valid`=0 and `rsp_pa`=0.
- R5: On a hit, `rsp_pg_valid` equals the valid bit of the selected half. A tag match on an invalid half reports `rsp_hit`=1 and `rsp_pg_valid`=0. `rsp_pa` is still formed from that half's frame.
- R6: An entry whose two valid bits are both 0 never matches, whatever its tag.
- R7: When several entries match, the entry with the lowest index supplies the response.
- R8: A write and a lookup in the same cycle: the lookup sees the contents from before the write. A lookup issued in the following cycle sees the new contents.
- R9: A write whose index is 48 or more changes no entry.
- R10: Virtual address bits 63:40 have no effect on the lookup.
- R11: After a synchronous active-low reset, every entry is invalid and `rsp_stb` is 0. A lookup of any address, including page-pair number 0, then misses.
- R12: In every cycle where `rsp_stb` is 0, `rsp_hit`, `rsp_pg_valid` and `rsp_pa` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | 6 | Entry index to load |
| wr_tag | input | 27 | Virtual page-pair number (address bits 39:13) |
| wr_pfn_even | input | 24 | Physical frame for the even page |
| wr_pfn_odd | input | 24 | Physical frame for the odd page |
| wr_v_even | input | 1 | Valid bit of the even half |
| wr_v_odd | input | 1 | Valid bit of the odd half |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Virtual address to translate |
| rsp_stb | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | A tag matched |
| rsp_pg_valid | output | 1 | The selected half is valid |
| rsp_pa | output | 36 | Translated physical address |

## Verification
The assertions check on every cycle:
- the two-cycle request-to-response spacing;
- that the page offset passes through on hits;
- that an idle response is all zero;
- that a valid page is never reported without a hit;
- that the match-resolution grant is at most one-hot and covers only matching entries;
- that an out-of-range write leaves the storage untouched.

Other behaviours depend on stored history, so only the bench scenarios can show them:
- that the lowest-index entry wins among duplicate tags;
- that a same-cycle write stays invisible to the lookup beside it;
- that an out-of-range index does not alias onto a real entry;
- that the upper address bits are ignored.

// File: rtl/ptlb_pkg.sv
// Shared definitions for the paired-page translation buffer.
// Assumes: default geometry of 48 entries, 64-bit virtual and 36-bit
// physical addresses, fixed 4 KB pages.
package ptlb_pkg;

    localparam int DEF_ENTRIES  = 48;
    localparam int DEF_VA_W     = 64;
    localparam int DEF_PA_W     = 36;
    localparam int DEF_PG_SHIFT = 12;
    localparam int DEF_TAG_HI   = 39;

    // Which half of a page pair a lookup addresses (virtual address bit 12).
    typedef enum logic {
        HALF_EVEN = 1'b0,
        HALF_ODD  = 1'b1
    } half_e;

endpackage

// File: rtl/ptlb_entry_store.sv
// Entry storage: one tag, two frames and two valid bits per entry.
// The indexed write lands at the clock edge, so a reader in the same
// cycle still sees the old contents. Reset clears only the valid bits.
// Assumes: an index at or above N_ENTRIES matches no entry and is dropped.
module ptlb_entry_store #(
    parameter int N_ENTRIES = 48,
    parameter int TAG_W     = 27,
    parameter int PFN_W     = 24,
    parameter int IDX_W     = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [TAG_W-1:0]                  wr_tag,
    input  logic [PFN_W-1:0]                  wr_pfn_e,
    input  logic [PFN_W-1:0]                  wr_pfn_o,
    input  logic                              wr_v_e,
    input  logic                              wr_v_o,
    output logic [N_ENTRIES-1:0][TAG_W-1:0]   tag_q,
    output logic [N_ENTRIES-1:0][PFN_W-1:0]   pfn_e_q,
    output logic [N_ENTRIES-1:0][PFN_W-1:0]   pfn_o_q,
    output logic [N_ENTRIES-1:0]              v_e_q,
    output logic [N_ENTRIES-1:0]              v_o_q
);

    localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(N_ENTRIES);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

        // Valid bits: cleared by reset, replaced by a write to this index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_e_q[i] <= 1'b0;
                v_o_q[i] <= 1'b0;
            end else if (wr_en && wr_idx == MY_IDX) begin
                v_e_q[i] <= wr_v_e;
                v_o_q[i] <= wr_v_o;
            end
        end

        // Tag and frames: payload only, needs no reset.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == MY_IDX) begin
                tag_q[i]   <= wr_tag;
                pfn_e_q[i] <= wr_pfn_e;
                pfn_o_q[i] <= wr_pfn_o;
            end
        end
    end

    AST_BADIDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && {1'b0, wr_idx} >= LIMIT) |=> ($stable(v_e_q) && $stable(v_o_q) && $stable(tag_q))); // R9

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && {1'b0, wr_idx} < LIMIT) |=>
            (v_e_q[$past(wr_idx)] == $past(wr_v_e) && v_o_q[$past(wr_idx)] == $past(wr_v_o))); // R8

endmodule

// File: rtl/ptlb_match.sv
// Parallel tag compare and match resolution. Every entry with at least
// one valid half compares its tag with the lookup tag. The lowest-index
// match is isolated into a one-hot grant.
// Assumes: purely combinational; the caller registers the result.
module ptlb_match #(
    parameter int N_ENTRIES = 48,
    parameter int TAG_W     = 27
) (
    input  logic [TAG_W-1:0]                lk_tag,
    input  logic [N_ENTRIES-1:0][TAG_W-1:0] tag_q,
    input  logic [N_ENTRIES-1:0]            v_e_q,
    input  logic [N_ENTRIES-1:0]            v_o_q,
    output logic [N_ENTRIES-1:0]            match_vec,
    output logic [N_ENTRIES-1:0]            grant,
    output logic                            any_hit
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        // Entry i matches when it holds a live half and its tag is equal.
        assign match_vec[i] = (v_e_q[i] | v_o_q[i]) && (tag_q[i] == lk_tag);
    end

    // Lowest set bit wins: isolate it with a two's-complement mask.
    always_comb begin
        grant   = match_vec & (~match_vec + N_ENTRIES'(1));
        any_hit = |match_vec;
    end

endmodule

// File: rtl/ptlb_resolve.sv
// Second lookup stage: picks the even or odd frame of the captured entry,
// joins the page offset and registers the response. Outputs are zero
// whenever no response is present.
// Assumes: inputs are first-stage registers from the same request.
module ptlb_resolve import ptlb_pkg::*; #(
    parameter int PFN_W = 24,
    parameter int OFF_W = 12,
    parameter int PA_W  = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_req,
    input  logic             s1_hit,
    input  logic [PFN_W-1:0] s1_pfn_e,
    input  logic [PFN_W-1:0] s1_pfn_o,
    input  logic             s1_v_e,
    input  logic             s1_v_o,
    input  half_e            s1_half,
    input  logic [OFF_W-1:0] s1_off,
    output logic             rsp_stb,
    output logic             rsp_hit,
    output logic             rsp_pg_valid,
    output logic [PA_W-1:0]  rsp_pa
);

    logic [PFN_W-1:0] pick_pfn;
    logic             pick_v;

    // Half select from virtual address bit 12.
    always_comb begin
        pick_pfn = (s1_half == HALF_ODD) ? s1_pfn_o : s1_pfn_e;
        pick_v   = (s1_half == HALF_ODD) ? s1_v_o   : s1_v_e;
    end

    // Response register; zeros on idle cycles and misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_stb      <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_pg_valid <= 1'b0;
            rsp_pa       <= '0;
        end else begin
            rsp_stb <= s1_req;
            if (s1_req && s1_hit) begin
                rsp_hit      <= 1'b1;
                rsp_pg_valid <= pick_v;
                rsp_pa       <= {pick_pfn, s1_off};
            end else begin
                rsp_hit      <= 1'b0;
                rsp_pg_valid <= 1'b0;
                rsp_pa       <= '0;
            end
        end
    end

    AST_PGV_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pg_valid |-> rsp_hit); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_stb |-> (!rsp_hit && !rsp_pg_valid && rsp_pa == '0)); // R12

endmodule

// File: rtl/paired_tlb.sv
// Paired-page translation buffer top.
// Stage 1 compares tags in parallel and resolves the lowest-index match.
// It captures that entry's two frames, so a write in a later cycle cannot
// disturb a lookup in flight. Stage 2 selects the half and registers the
// response.
// Assumes: fixed 4 KB pages; virtual address bits above TAG_HI are ignored.
module paired_tlb import ptlb_pkg::*; #(
    parameter int N_ENTRIES = DEF_ENTRIES,
    parameter int VA_W      = DEF_VA_W,
    parameter int PA_W      = DEF_PA_W,
    parameter int PG_SHIFT  = DEF_PG_SHIFT,
    parameter int TAG_HI    = DEF_TAG_HI,
    localparam int TAG_LO   = PG_SHIFT + 1,
    localparam int TAG_W    = TAG_HI - TAG_LO + 1,
    localparam int PFN_W    = PA_W - PG_SHIFT,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_v_even,
    input  logic              wr_v_odd,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    output logic              rsp_stb,
    output logic              rsp_hit,
    output logic              rsp_pg_valid,
    output logic [PA_W-1:0]   rsp_pa
);

    logic [N_ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [N_ENTRIES-1:0][PFN_W-1:0] pfn_e_q;
    logic [N_ENTRIES-1:0][PFN_W-1:0] pfn_o_q;
    logic [N_ENTRIES-1:0]            v_e_q;
    logic [N_ENTRIES-1:0]            v_o_q;
    logic [N_ENTRIES-1:0]            match_vec;
    logic [N_ENTRIES-1:0]            grant;
    logic                            any_hit;

    logic [PFN_W-1:0] sel_pfn_e, sel_pfn_o;
    logic             sel_v_e, sel_v_o;

    logic             s1_req, s1_hit, s1_v_e, s1_v_o;
    logic [PFN_W-1:0] s1_pfn_e, s1_pfn_o;
    half_e            s1_half;
    logic [PG_SHIFT-1:0] s1_off;

    logic unused_va_hi;
    assign unused_va_hi = ^lk_va[VA_W-1:TAG_HI+1];

    ptlb_entry_store #(
        .N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_pfn_e(wr_pfn_even), .wr_pfn_o(wr_pfn_odd),
        .wr_v_e(wr_v_even), .wr_v_o(wr_v_odd),
        .tag_q(tag_q), .pfn_e_q(pfn_e_q), .pfn_o_q(pfn_o_q),
        .v_e_q(v_e_q), .v_o_q(v_o_q)
    );

    ptlb_match #(
        .N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W)
    ) u_match (
        .lk_tag(lk_va[TAG_HI:TAG_LO]), .tag_q(tag_q),
        .v_e_q(v_e_q), .v_o_q(v_o_q),
        .match_vec(match_vec), .grant(grant), .any_hit(any_hit)
    );

    // AND-OR mux of the granted entry's frames and valid bits.
    always_comb begin
        sel_pfn_e = '0;
        sel_pfn_o = '0;
        sel_v_e   = 1'b0;
        sel_v_o   = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            sel_pfn_e = sel_pfn_e | (pfn_e_q[i] & {PFN_W{grant[i]}});
            sel_pfn_o = sel_pfn_o | (pfn_o_q[i] & {PFN_W{grant[i]}});
            sel_v_e   = sel_v_e   | (v_e_q[i] & grant[i]);
            sel_v_o   = sel_v_o   | (v_o_q[i] & grant[i]);
        end
    end

    // First-stage register: captures the resolved entry and request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_req   <= 1'b0;
            s1_hit   <= 1'b0;
            s1_pfn_e <= '0;
            s1_pfn_o <= '0;
            s1_v_e   <= 1'b0;
            s1_v_o   <= 1'b0;
            s1_half  <= HALF_EVEN;
            s1_off   <= '0;
        end else begin
            s1_req   <= lk_req;
            s1_hit   <= lk_req && any_hit;
            s1_pfn_e <= sel_pfn_e;
            s1_pfn_o <= sel_pfn_o;
            s1_v_e   <= sel_v_e;
            s1_v_o   <= sel_v_o;
            s1_half  <= half_e'(lk_va[PG_SHIFT]);
            s1_off   <= lk_va[PG_SHIFT-1:0];
        end
    end

    ptlb_resolve #(
        .PFN_W(PFN_W), .OFF_W(PG_SHIFT), .PA_W(PA_W)
    ) u_resolve (
        .clk(clk), .rst_n(rst_n),
        .s1_req(s1_req), .s1_hit(s1_hit),
        .s1_pfn_e(s1_pfn_e), .s1_pfn_o(s1_pfn_o),
        .s1_v_e(s1_v_e), .s1_v_o(s1_v_o),
        .s1_half(s1_half), .s1_off(s1_off),
        .rsp_stb(rsp_stb), .rsp_hit(rsp_hit),
        .rsp_pg_valid(rsp_pg_valid), .rsp_pa(rsp_pa)
    );

    AST_TWO_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (rsp_stb == $past(lk_req, 2))); // R1

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && rsp_hit) |->
            (rsp_pa[PG_SHIFT-1:0] == $past(lk_va[PG_SHIFT-1:0], 2))); // R3

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~match_vec) == '0)); // R7

    AST_GRANT_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (grant != '0)); // R2

endmodule

// File: tb/paired_tlb_bench.sv
// Scoreboard bench: the driver computes each expected response from a
// behavioural model and queues it; the monitor pops and compares.
module paired_tlb_bench;

    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [5:0]  wr_idx;
    logic [26:0] wr_tag;
    logic [23:0] wr_pfn_even, wr_pfn_odd;
    logic        wr_v_even, wr_v_odd;
    logic        lk_req;
    logic [63:0] lk_va;
    logic        rsp_stb, rsp_hit, rsp_pg_valid;
    logic [35:0] rsp_pa;

    always #5 clk = ~clk;

    paired_tlb u_paired_tlb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
        .wr_v_even(wr_v_even), .wr_v_odd(wr_v_odd),
        .lk_req(lk_req), .lk_va(lk_va),
        .rsp_stb(rsp_stb), .rsp_hit(rsp_hit),
        .rsp_pg_valid(rsp_pg_valid), .rsp_pa(rsp_pa)
    );

    // Behavioural model of the entries.
    logic [26:0] m_tag [N];
    logic [23:0] m_pe  [N];
    logic [23:0] m_po  [N];
    logic        m_ve  [N];
    logic        m_vo  [N];

    typedef struct packed {
        logic [31:0] cyc;
        logic        hit;
        logic        pgv;
        logic [35:0] pa;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic logic [63:0] mkva(input logic [23:0] hi, input logic [26:0] tag,
                                         input logic odd, input logic [11:0] off);
        return {hi, tag, odd, off};
    endfunction

    // Drive one cycle; optionally write and/or look up, queue the expectation.
    task automatic issue(input bit do_wr, input logic [5:0] idx, input logic [26:0] tag,
                         input logic [23:0] pe, input logic [23:0] po,
                         input bit ve, input bit vo,
                         input bit do_lk, input logic [63:0] va, input string req);
        exp_t e;
        @(negedge clk);
        wr_en = do_wr; wr_idx = idx; wr_tag = tag;
        wr_pfn_even = pe; wr_pfn_odd = po; wr_v_even = ve; wr_v_odd = vo;
        lk_req = do_lk; lk_va = va;
        if (do_lk) begin
            e = '0;
            e.cyc = cyc;
            for (int i = N - 1; i >= 0; i--) begin
                if ((m_ve[i] || m_vo[i]) && m_tag[i] == va[39:13]) begin
                    e.hit = 1'b1;
                    e.pgv = va[12] ? m_vo[i] : m_ve[i];
                    e.pa  = {(va[12] ? m_po[i] : m_pe[i]), va[11:0]};
                end
            end
            exp_q.push_back(e);
            req_q.push_back(req);
        end
        if (do_wr && idx < 6'(N)) begin
            m_tag[idx] = tag; m_pe[idx] = pe; m_po[idx] = po;
            m_ve[idx] = ve; m_vo[idx] = vo;
        end
    endtask

    task automatic wr(input int idx, input logic [26:0] tag, input logic [23:0] pe,
                      input logic [23:0] po, input bit ve, input bit vo);
        issue(1'b1, 6'(idx), tag, pe, po, ve, vo, 1'b0, '0, "");
    endtask

    task automatic lk(input logic [63:0] va, input string req);
        issue(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b1, va, req);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1'b0; lk_req = 1'b0;
        end
    endtask

    // Monitor: compares each response with the queued expectation.
    always @(negedge clk) begin
        if (mon_en) begin
            if (rsp_stb) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "response with no request: act stb=1 exp stb=0");
                end else begin
                    exp_t  e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(rsp_hit == e.hit && rsp_pg_valid == e.pgv && rsp_pa == e.pa
                          && cyc == int'(e.cyc) + 2, r,
                          $sformatf("act hit=%0b pgv=%0b pa=%h cyc=%0d exp hit=%0b pgv=%0b pa=%h cyc=%0d",
                                    rsp_hit, rsp_pg_valid, rsp_pa, cyc,
                                    e.hit, e.pgv, e.pa, e.cyc + 2));
                end
            end else if (rsp_hit || rsp_pg_valid || rsp_pa != '0) begin
                check(1'b0, "R12", $sformatf("idle outputs act hit=%0b pgv=%0b pa=%h exp 0/0/0",
                                             rsp_hit, rsp_pg_valid, rsp_pa));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act running exp finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0; m_pe[i] = '0; m_po[i] = '0; m_ve[i] = 1'b0; m_vo[i] = 1'b0;
        end
        rst_n = 1'b0;
        wr_en = 1'b0; wr_idx = '0; wr_tag = '0; wr_pfn_even = '0; wr_pfn_odd = '0;
        wr_v_even = 1'b0; wr_v_odd = 1'b0; lk_req = 1'b0; lk_va = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_stb == 1'b0 && rsp_hit == 1'b0, "R11",
              $sformatf("reset state act stb=%0b hit=%0b exp 0/0", rsp_stb, rsp_hit));
        mon_en = 1'b1;

        // R11 / R6: empty buffer misses even for page-pair 0.
        lk(mkva(24'h0, 27'h0, 1'b0, 12'h000), "R11");
        lk(mkva(24'h0, 27'h0, 1'b1, 12'h123), "R11");

        // Load entries 0..7 with distinct tags.
        for (int i = 0; i < 8; i++)
            wr(i, 27'h0ABC00 + 27'(i * 3), 24'h100000 + 24'(i * 2), 24'h100001 + 24'(i * 2), 1'b1, 1'b1);
        // R2 / R3: even and odd halves, varying offsets, back to back (R1).
        lk(mkva(24'h0, 27'h0ABC00, 1'b0, 12'hABC), "R3");
        lk(mkva(24'h0, 27'h0ABC00, 1'b1, 12'h001), "R3");
        lk(mkva(24'h0, 27'h0ABC15, 1'b1, 12'hFFF), "R2");
        lk(mkva(24'h0, 27'h0ABC09, 1'b0, 12'h000), "R1");
        // R4: misses.
        lk(mkva(24'h0, 27'h0ABC01, 1'b0, 12'h555), "R4");
        lk(mkva(24'h0, 27'h7FFFFFF, 1'b1, 12'h555), "R4");

        // R5: odd half invalid.
        wr(12, 27'h1234567, 24'hAAAAAA, 24'hBBBBBB, 1'b1, 1'b0);
        lk(mkva(24'h0, 27'h1234567, 1'b1, 12'h0F0), "R5");
        lk(mkva(24'h0, 27'h1234567, 1'b0, 12'h0F0), "R5");

        // R6: both halves invalid never matches.
        wr(13, 27'h0BEEF00, 24'h111111, 24'h222222, 1'b0, 1'b0);
        lk(mkva(24'h0, 27'h0BEEF00, 1'b0, 12'h010), "R6");

        // R7: duplicate tags at 30 and 17; lowest index supplies the frame.
        wr(30, 27'h0DDDDDD, 24'h300000, 24'h300001, 1'b1, 1'b1);
        wr(17, 27'h0DDDDDD, 24'h170000, 24'h170001, 1'b1, 1'b1);
        lk(mkva(24'h0, 27'h0DDDDDD, 1'b1, 12'h321), "R7");
        lk(mkva(24'h0, 27'h0DDDDDD, 1'b0, 12'h321), "R7");

        // R8: same-cycle write and lookup sees old, next cycle sees new.
        issue(1'b1, 6'd3, 27'h0ABC09, 24'h0FEDCB, 24'h0FEDCA, 1'b1, 1'b1,
              1'b1, mkva(24'h0, 27'h0ABC09, 1'b0, 12'h444), "R8");
        lk(mkva(24'h0, 27'h0ABC09, 1'b0, 12'h444), "R8");
        issue(1'b1, 6'd47, 27'h0C0FFEE, 24'h470000, 24'h470001, 1'b1, 1'b1,
              1'b1, mkva(24'h0, 27'h0C0FFEE, 1'b1, 12'h047), "R8");
        lk(mkva(24'h0, 27'h0C0FFEE, 1'b1, 12'h047), "R8");

        // R9: index 50 (would alias to 2 if wrapped) changes nothing.
        wr(50, 27'h0FACADE, 24'h500000, 24'h500001, 1'b1, 1'b1);
        lk(mkva(24'h0, 27'h0FACADE, 1'b0, 12'h050), "R9");
        lk(mkva(24'h0, 27'h0ABC06, 1'b1, 12'h002), "R9");

        // R10: upper address bits ignored.
        lk(mkva(24'hFFFFFF, 27'h0ABC0C, 1'b0, 12'h7A7), "R10");
        lk(mkva(24'h5A5A5A, 27'h0ABC0C, 1'b1, 12'h7A7), "R10");

        idle(3);
        // Mixed stream of known and unknown tags, back to back.
        for (int k = 0; k < 40; k++) begin
            logic [26:0] t;
            logic [31:0] r;
            r = $urandom;
            t = (r[0]) ? (27'h0ABC00 + 27'((r[7:4] % 8) * 3)) : {r[31:8], 3'b101};
            lk(mkva(r[31:8], t, r[1], r[19:8]), "R2");
        end
        idle(4);
        check(exp_q.size() == 0, "R1",
              $sformatf("pending responses act %0d exp 0", exp_q.size()));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule